// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals and the index signal of an incremental encoder into a position count at four counts per encoder line. Each input is synchronized to the core clock and can be cleaned by a digital spike filter of programmable length. The count lives inside a range set by a ceiling value and wraps at either end. An index pulse can preset the count to zero when it arrives while the phases show a chosen level pair. Counting events are recorded in sticky status flags that drive one interrupt line through a mask.

Software configures and reads the block through a word-addressed register port with a write strobe and a combinational read path. The configuration is frozen while the counter runs: only the run bit stays writable then, so the decoding rules cannot change in the middle of a motion.

Top module: `qenc_position_counter`

Register map (word address in `reg_addr`): 0 control, 1 filter length, 2 count (read only), 3 ceiling, 4 status, 5 status mask. Control bits: 0 run, 1 filter on, 2 A polarity, 3 B polarity, 4 index edge, 5 swap phases, 6 alternate mode, 7 illegal-transition flag, 8 wrap-only mode, 10:9 index gate code. Status and mask bits: 0 watchdog, 1 reset while counting down, 2 reset while counting up, 3 direction change, 4 FIFO entry, 5 FIFO critical.

## Requirements
- R1: After reset, control reads 0x11C, filter length 0, count 0, ceiling 0xFFFFFFFF, mask 0x3F, status 0 and the interrupt is low.
- R2: While running, every edge of either phase moves the count by one: with phases written as {A,B}, the order 00, 10, 11, 01, 00 counts up and the reverse order counts down.
- R3: A step up while the count is at or above the ceiling gives 0 and sets status bit 2; a step down from 0 gives the ceiling value and sets status bit 1.
- R4: A sample where both phases change leaves the count unchanged and sets control bit 7; writing 1 to control bit 7 clears it, even while running.
- R5: With control bit 5 set, A and B are exchanged before decoding, so the same input motion counts in the opposite direction.
- R6: With control bit 8 clear, a rising index edge presets the count to 0 only when the phase levels {A,B} equal the gate code in control bits 10:9.
- R7: With control bit 8 set, index edges leave the count unchanged.
- R8: With control bit 4 clear, the index input is inverted, so its falling edge is the one that presets the count.
- R9: With control bit 1 set, a phase level reaches the decoder only after holding for filter length plus 2 clock cycles; a shorter pulse has no effect. The filter register reads back the written length.
- R10: While the run bit is set, writes to the filter and ceiling registers and to control bits other than bit 0 and the bit 7 clear are ignored.
- R11: With the run bit clear, phase changes leave the count unchanged.
- R12: Status bits are cleared by writing 1; a step opposite to the previous step sets status bit 3; the interrupt is high exactly when a status bit is set whose mask bit is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| enc_a | input | 1 | Encoder phase A |
| enc_b | input | 1 | Encoder phase B |
| enc_idx | input | 1 | Encoder index |
| irq | output | 1 | Unmasked status interrupt |

## Verification
The main stimulus is a walk through phase states that runs forward through four full cycles, crosses the ceiling upward and then back through zero downward, inserts a double change and resumes. This separates correct direction decoding from off-by-one wrap values and shows that an illegal step is dropped. The same single-edge motion is then repeated with the phases swapped, with the counter stopped and behind the filter with a pulse one cycle shorter than the filter length, which tells apart the direction inversion, the run gate and the minimum-length rule. Index pulses are applied with matching and mismatching phase levels, in both reset modes and with both index polarities.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

   // register word addresses
   localparam int unsigned ADR_CTRL  = 0;
   localparam int unsigned ADR_FILT  = 1;
   localparam int unsigned ADR_COUNT = 2;
   localparam int unsigned ADR_CEIL  = 3;
   localparam int unsigned ADR_STAT  = 4;
   localparam int unsigned ADR_MASK  = 5;

   // status / mask bit positions
   localparam int unsigned EV_WDOG    = 0;
   localparam int unsigned EV_WRAP_DN = 1;
   localparam int unsigned EV_WRAP_UP = 2;
   localparam int unsigned EV_DIR     = 3;
   localparam int unsigned EV_FENTRY  = 4;
   localparam int unsigned EV_FCRIT   = 5;
   localparam int unsigned EV_W       = 6;

   localparam int unsigned CTRL_W = 11;

   // field order gives the bit positions (run at bit 0, gate at 10:9)
   typedef struct packed {
      logic [1:0] gate;
      logic       wrap_only;
      logic       bad_seen;
      logic       alt_mode;
      logic       swap;
      logic       pol_idx;
      logic       pol_b;
      logic       pol_a;
      logic       flt_on;
      logic       run;
   } qenc_ctrl_t;

   localparam logic [CTRL_W-1:0] CTRL_RST = 11'h11C;

endpackage

// File: rtl/qenc_input_filter.sv
module qenc_input_filter #(
   parameter int unsigned FLT_W       = 21,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             raw,
   input  logic             flt_on,
   input  logic [FLT_W-1:0] flt_max,
   output logic             clean
);

   localparam int unsigned CW = FLT_W + 1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sampled;
   logic [CW-1:0]          hold_cnt;
   logic [CW-1:0]          hold_lim;

   // synchronizer chain, oldest stage at the top
   always_ff @(posedge clk) begin
      if (rst) sync_q <= '0;
      else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
   end
   assign sampled = sync_q[SYNC_STAGES-1];

   // a differing level must be seen (flt_max + 2) cycles in a row
   assign hold_lim = {1'b0, flt_max} + CW'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         clean    <= 1'b0;
         hold_cnt <= '0;
      end else if (!flt_on) begin
         clean    <= sampled;
         hold_cnt <= '0;
      end else if (sampled == clean) begin
         hold_cnt <= '0;
      end else if (hold_cnt == hold_lim) begin
         clean    <= sampled;
         hold_cnt <= '0;
      end else begin
         hold_cnt <= hold_cnt + CW'(1);
      end
   end

endmodule

// File: rtl/qenc_decoder.sv
module qenc_decoder (
   input  logic       clk,
   input  logic       rst,
   input  logic       in_a,
   input  logic       in_b,
   input  logic       in_idx,
   input  logic       pol_a,
   input  logic       pol_b,
   input  logic       pol_idx,
   input  logic       swap,
   input  logic [1:0] gate,
   output logic       step_up,
   output logic       step_dn,
   output logic       bad_step,
   output logic       idx_evt
);

   logic pa, pb, da, db, di;
   logic prev_a, prev_b, prev_i;
   logic chg_a, chg_b, fwd;

   // polarity first (bit set keeps the level), then optional exchange
   assign pa = pol_a ? in_a : ~in_a;
   assign pb = pol_b ? in_b : ~in_b;
   assign di = pol_idx ? in_idx : ~in_idx;
   assign da = swap ? pb : pa;
   assign db = swap ? pa : pb;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_a <= 1'b0;
         prev_b <= 1'b0;
         prev_i <= 1'b0;
      end else begin
         prev_a <= da;
         prev_b <= db;
         prev_i <= di;
      end
   end

   assign chg_a    = da ^ prev_a;
   assign chg_b    = db ^ prev_b;
   assign fwd      = prev_b ^ da;
   assign bad_step = chg_a & chg_b;
   assign step_up  = (chg_a ^ chg_b) & fwd;
   assign step_dn  = (chg_a ^ chg_b) & ~fwd;
   assign idx_evt  = di & ~prev_i & ({da, db} == gate);

endmodule

// File: rtl/qenc_count_core.sv
module qenc_count_core #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             active,
   input  logic             step_up,
   input  logic             step_dn,
   input  logic             idx_evt,
   input  logic             wrap_only,
   input  logic [CNT_W-1:0] ceil,
   output logic [CNT_W-1:0] count,
   output logic             ev_wrap_up,
   output logic             ev_wrap_dn,
   output logic             ev_dir
);

   logic dir_up;
   logic idx_rst, up_wrap, dn_wrap;

   assign idx_rst = active & idx_evt & ~wrap_only;
   assign up_wrap = active & step_up & (count >= ceil) & ~idx_rst;
   assign dn_wrap = active & step_dn & (count == '0) & ~idx_rst;

   assign ev_wrap_up = up_wrap | (idx_rst & dir_up);
   assign ev_wrap_dn = dn_wrap | (idx_rst & ~dir_up);
   assign ev_dir     = active & ((step_up & ~dir_up) | (step_dn & dir_up));

   always_ff @(posedge clk) begin
      if (rst) begin
         count  <= '0;
         dir_up <= 1'b1;
      end else if (active) begin
         if (idx_rst)      count <= '0;
         else if (step_up) count <= (count >= ceil) ? '0 : count + CNT_W'(1);
         else if (step_dn) count <= (count == '0) ? ceil : count - CNT_W'(1);
         if (step_up | step_dn) dir_up <= step_up;
      end
   end

endmodule

// File: rtl/qenc_regs.sv
module qenc_regs
   import qenc_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned FLT_W  = 21,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   input  logic [CNT_W-1:0]  count,
   input  logic [EV_W-1:0]   ev_set,
   input  logic              bad_set,
   output qenc_ctrl_t        ctrl,
   output logic [FLT_W-1:0]  flt_max,
   output logic [CNT_W-1:0]  ceil,
   output logic [EV_W-1:0]   stat,
   output logic [EV_W-1:0]   mask,
   output logic [31:0]       rdata,
   output logic              irq
);

   logic wr_ctrl, wr_filt, wr_ceil, wr_stat, wr_mask;
   logic unused_wdata;
   qenc_ctrl_t wctrl;

   assign wr_ctrl = we && (addr == ADDR_W'(ADR_CTRL));
   assign wr_filt = we && (addr == ADDR_W'(ADR_FILT));
   assign wr_ceil = we && (addr == ADDR_W'(ADR_CEIL));
   assign wr_stat = we && (addr == ADDR_W'(ADR_STAT));
   assign wr_mask = we && (addr == ADDR_W'(ADR_MASK));
   assign wctrl   = qenc_ctrl_t'(wdata[CTRL_W-1:0]);
   assign unused_wdata = ^wdata;

   // control: configuration only while stopped, run always, bit 7 sticky
   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl <= qenc_ctrl_t'(CTRL_RST);
      end else begin
         if (wr_ctrl) begin
            if (!ctrl.run) begin
               ctrl.gate      <= wctrl.gate;
               ctrl.wrap_only <= wctrl.wrap_only;
               ctrl.alt_mode  <= wctrl.alt_mode;
               ctrl.swap      <= wctrl.swap;
               ctrl.pol_idx   <= wctrl.pol_idx;
               ctrl.pol_b     <= wctrl.pol_b;
               ctrl.pol_a     <= wctrl.pol_a;
               ctrl.flt_on    <= wctrl.flt_on;
            end
            ctrl.run <= wctrl.run;
         end
         if (bad_set)                        ctrl.bad_seen <= 1'b1;
         else if (wr_ctrl && wctrl.bad_seen) ctrl.bad_seen <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         flt_max <= '0;
         ceil    <= '1;
         mask    <= '1;
      end else begin
         if (wr_filt && !ctrl.run) flt_max <= wdata[FLT_W-1:0];
         if (wr_ceil && !ctrl.run) ceil    <= wdata[CNT_W-1:0];
         if (wr_mask)              mask    <= wdata[EV_W-1:0];
      end
   end

   // status: hardware set wins over a same-cycle clear
   for (genvar gi = 0; gi < EV_W; gi++) begin : g_stat
      always_ff @(posedge clk) begin
         if (rst)                         stat[gi] <= 1'b0;
         else if (ev_set[gi])             stat[gi] <= 1'b1;
         else if (wr_stat && wdata[gi])   stat[gi] <= 1'b0;
      end
   end

   assign irq = |(stat & ~mask);

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(ADR_CTRL))       rdata = 32'(ctrl);
      else if (addr == ADDR_W'(ADR_FILT))  rdata = 32'(flt_max);
      else if (addr == ADDR_W'(ADR_COUNT)) rdata = 32'(count);
      else if (addr == ADDR_W'(ADR_CEIL))  rdata = 32'(ceil);
      else if (addr == ADDR_W'(ADR_STAT))  rdata = 32'(stat);
      else if (addr == ADDR_W'(ADR_MASK))  rdata = 32'(mask);
   end

endmodule

// File: rtl/qenc_position_counter.sv
module qenc_position_counter
   import qenc_pkg::*;
#(
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned FLT_W       = 21,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              enc_a,
   input  logic              enc_b,
   input  logic              enc_idx,
   output logic              irq
);

   localparam int unsigned N_IN = 3;

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W must lie in 2..32");
   end
   if (FLT_W < 1 || FLT_W > 31) begin : g_bad_flt
      $error("FLT_W must lie in 1..31");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must be at least 3");
   end

   qenc_ctrl_t        ctrl;
   logic [FLT_W-1:0]  flt_max;
   logic [CNT_W-1:0]  ceil, count;
   logic [EV_W-1:0]   stat, mask, ev_set;
   logic [N_IN-1:0]   raw_in, clean_in;
   logic              step_up, step_dn, bad_step, idx_evt;
   logic              ev_wrap_up, ev_wrap_dn, ev_dir;
   logic              active, bad_set;

   // plain views used by the bound checker
   logic ctrl_run, ctrl_wrap_only, ctrl_bad_seen;
   assign ctrl_run       = ctrl.run;
   assign ctrl_wrap_only = ctrl.wrap_only;
   assign ctrl_bad_seen  = ctrl.bad_seen;

   assign active  = ctrl.run & ~ctrl.alt_mode;
   assign bad_set = active & bad_step;
   assign raw_in  = {enc_idx, enc_b, enc_a};

   for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
      qenc_input_filter #(
         .FLT_W       (FLT_W),
         .SYNC_STAGES (SYNC_STAGES)
      ) flt_i (
         .clk     (clk),
         .rst     (rst),
         .raw     (raw_in[gi]),
         .flt_on  (ctrl.flt_on),
         .flt_max (flt_max),
         .clean   (clean_in[gi])
      );
   end

   qenc_decoder dec_i (
      .clk      (clk),
      .rst      (rst),
      .in_a     (clean_in[0]),
      .in_b     (clean_in[1]),
      .in_idx   (clean_in[2]),
      .pol_a    (ctrl.pol_a),
      .pol_b    (ctrl.pol_b),
      .pol_idx  (ctrl.pol_idx),
      .swap     (ctrl.swap),
      .gate     (ctrl.gate),
      .step_up  (step_up),
      .step_dn  (step_dn),
      .bad_step (bad_step),
      .idx_evt  (idx_evt)
   );

   qenc_count_core #(.CNT_W(CNT_W)) core_i (
      .clk        (clk),
      .rst        (rst),
      .active     (active),
      .step_up    (step_up),
      .step_dn    (step_dn),
      .idx_evt    (idx_evt),
      .wrap_only  (ctrl.wrap_only),
      .ceil       (ceil),
      .count      (count),
      .ev_wrap_up (ev_wrap_up),
      .ev_wrap_dn (ev_wrap_dn),
      .ev_dir     (ev_dir)
   );

   always_comb begin
      ev_set             = '0;
      ev_set[EV_WRAP_UP] = ev_wrap_up;
      ev_set[EV_WRAP_DN] = ev_wrap_dn;
      ev_set[EV_DIR]     = ev_dir;
   end

   qenc_regs #(
      .CNT_W  (CNT_W),
      .FLT_W  (FLT_W),
      .ADDR_W (ADDR_W)
   ) regs_i (
      .clk     (clk),
      .rst     (rst),
      .we      (reg_we),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .count   (count),
      .ev_set  (ev_set),
      .bad_set (bad_set),
      .ctrl    (ctrl),
      .flt_max (flt_max),
      .ceil    (ceil),
      .stat    (stat),
      .mask    (mask),
      .rdata   (reg_rdata),
      .irq     (irq)
   );

endmodule

// File: rtl/qenc_position_counter_chk.sv
module qenc_position_counter_chk #(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst,
   input logic             active,
   input logic             run,
   input logic             wrap_only,
   input logic             bad_seen,
   input logic             step_up,
   input logic             bad_step,
   input logic             idx_evt,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] ceil
);

   // R11: a stopped counter keeps its value
   p_hold_stopped_r11: assert property (@(posedge clk) disable iff (rst)
      !active |=> $stable(count));

   // R10: ceiling cannot move while running
   p_ceil_locked_r10: assert property (@(posedge clk) disable iff (rst)
      $past(run) |-> $stable(ceil));

   // R2: the count moves by one, wraps or is preset
   p_unit_step_r2: assert property (@(posedge clk) disable iff (rst)
      (count != $past(count)) |->
         (count == $past(count) + CNT_W'(1) || count == $past(count) - CNT_W'(1) ||
          count == '0 || count == $past(ceil)));

   // R3: stepping up at the ceiling lands on zero
   p_wrap_up_r3: assert property (@(posedge clk) disable iff (rst)
      (active && step_up && !(idx_evt && !wrap_only) && count >= ceil) |=> (count == '0));

   // R4: an illegal transition raises the flag
   p_bad_flag_r4: assert property (@(posedge clk) disable iff (rst)
      (active && bad_step) |=> bad_seen);

   // R6: a qualified index presets the count
   p_idx_preset_r6: assert property (@(posedge clk) disable iff (rst)
      (active && idx_evt && !wrap_only) |=> (count == '0));

endmodule

bind qenc_position_counter qenc_position_counter_chk #(.CNT_W(CNT_W)) chk_i (
   .clk       (clk),
   .rst       (rst),
   .active    (active),
   .run       (ctrl_run),
   .wrap_only (ctrl_wrap_only),
   .bad_seen  (ctrl_bad_seen),
   .step_up   (step_up),
   .bad_step  (bad_step),
   .idx_evt   (idx_evt),
   .count     (count),
   .ceil      (ceil)
);

// File: tb/qenc_position_counter_tb.sv
module qenc_position_counter_tb_top;

   localparam time CLK_PERIOD = 10ns;
   localparam int  WDOG_CYC   = 100000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   qenc_position_counter dut_i (
      .clk       (clk),
      .rst       (rst),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .enc_a     (enc_a),
      .enc_b     (enc_b),
      .enc_idx   (enc_idx),
      .irq       (irq)
   );

   // phase walk: {A, B, expected count with ceiling 9}
   localparam logic [5:0] WALK [16] = '{
      {2'b10, 4'd1}, {2'b11, 4'd2}, {2'b01, 4'd3}, {2'b00, 4'd4},
      {2'b10, 4'd5}, {2'b11, 4'd6}, {2'b01, 4'd7}, {2'b00, 4'd8},
      {2'b10, 4'd9}, {2'b11, 4'd0}, {2'b10, 4'd9}, {2'b00, 4'd8},
      {2'b11, 4'd8}, {2'b01, 4'd9}, {2'b00, 4'd0}, {2'b01, 4'd9}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic set_ab(input logic a, input logic b, input int wait_cyc);
      @(negedge clk);
      enc_a = a; enc_b = b;
      repeat (wait_cyc) @(negedge clk);
   endtask

   task automatic set_idx(input logic v);
      @(negedge clk);
      enc_idx = v;
      repeat (8) @(negedge clk);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (WDOG_CYC) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (5) @(negedge clk);
      rst = 1'b0;

      // R1 reset values
      rd(0, v); check("R1 ctrl", v, 32'h11C);
      rd(1, v); check("R1 filter", v, 0);
      rd(2, v); check("R1 count", v, 0);
      rd(3, v); check("R1 ceiling", v, 32'hFFFF_FFFF);
      rd(4, v); check("R1 status", v, 0);
      rd(5, v); check("R1 mask", v, 32'h3F);
      check("R1 irq", {31'b0, irq}, 0);

      // R2 R3 R4 phase walk
      wr(3, 9);
      wr(0, 32'h11D);
      foreach (WALK[i]) begin
         set_ab(WALK[i][5], WALK[i][4], 8);
         rd(2, v);
         check($sformatf("R2 walk step %0d", i), v, 32'(WALK[i][3:0]));
      end
      rd(4, v); check("R3 wrap flags and R12 direction flag", v, 32'h0E);
      rd(0, v); check("R4 illegal flag set", v, 32'h19D);
      wr(0, 32'h081);
      rd(0, v); check("R4 illegal flag cleared", v, 32'h11D);

      // R12 masking and write-one-to-clear
      check("R12 irq masked", {31'b0, irq}, 0);
      wr(5, 32'h3B);
      @(negedge clk); check("R12 irq unmasked", {31'b0, irq}, 1);
      wr(4, 32'h04);
      rd(4, v); check("R12 status after clear", v, 32'h0A);
      check("R12 irq after clear", {31'b0, irq}, 0);

      // R10 locked while running
      wr(3, 5);
      rd(3, v); check("R10 ceiling locked", v, 9);
      wr(1, 7);
      rd(1, v); check("R10 filter locked", v, 0);
      wr(0, 32'h13D);
      rd(0, v); check("R10 ctrl locked", v, 32'h11D);

      // R11 stopped counter ignores motion (state 01, count 9)
      wr(0, 32'h11C);
      set_ab(1, 1, 8);
      set_ab(1, 0, 8);
      set_ab(0, 0, 8);
      rd(2, v); check("R11 count held while stopped", v, 9);

      // R5 swapped phases
      wr(3, 100);
      rd(3, v); check("R10 ceiling writable when stopped", v, 100);
      wr(0, 32'h13C);
      wr(0, 32'h13D);
      set_ab(1, 0, 8);
      rd(2, v); check("R5 swap reverses direction", v, 8);

      // R6 gated index preset, gate code 2 (A high, B low)
      wr(0, 32'h13C);
      wr(0, 32'h41C);
      wr(0, 32'h41D);
      set_idx(1);
      rd(2, v); check("R6 index preset with matching gate", v, 0);
      set_idx(0);
      set_ab(1, 1, 8);
      set_idx(1);
      rd(2, v); check("R6 index ignored with other levels", v, 1);
      set_idx(0);

      // R7 wrap-only mode ignores index
      wr(0, 32'h41C);
      set_ab(1, 0, 8);
      wr(0, 32'h51C);
      wr(0, 32'h51D);
      set_idx(1);
      rd(2, v); check("R7 index ignored in wrap-only mode", v, 1);
      set_idx(0);

      // R8 inverted index edge
      wr(0, 32'h51C);
      wr(0, 32'h40C);
      wr(0, 32'h40D);
      set_idx(1);
      rd(2, v); check("R8 physical rise ignored when inverted", v, 1);
      set_idx(0);
      rd(2, v); check("R8 physical fall presets when inverted", v, 0);

      // R9 spike filter, length 3 + 2 = 5 cycles
      wr(0, 32'h40C);
      wr(1, 3);
      rd(1, v); check("R9 filter readback", v, 3);
      wr(0, 32'h11E);
      wr(0, 32'h11F);
      @(negedge clk);
      enc_a = 1'b0;
      repeat (4) @(negedge clk);
      enc_a = 1'b1;
      repeat (12) @(negedge clk);
      rd(2, v); check("R9 short pulse rejected", v, 0);
      set_ab(0, 0, 12);
      rd(2, v); check("R9 held level passes", v, 100);

      summary();
      $finish;
   end

endmodule